// File: doc/BRIEF.md
# Prescaled Timer with Input Capture

This block is a 16-bit free-running counter with one input-capture channel behind a small byte-wide register bus. A 3-bit rate select picks how fast the counter advances. It can step on every bus clock, on every 2nd, 4th, 8th, 16th, 32nd or 64th bus clock, or on each synchronized rising edge of an external clock pin.

The capture pin passes through a two-flop synchronizer and then an edge detector. A two-bit edge-select field makes the channel respond to rising edges, to falling edges, to both, or to neither. On a qualifying edge the current count is copied into a 16-bit capture register, and the channel flag is set. When the flag and the interrupt enable are both set, an interrupt request is raised.

Software reads the captured value one byte at a time. Reading the high byte holds off further captures until the low byte has been read, so the two bytes always belong to the same event. To clear the flag, software reads the status register while the flag is set and then writes 0 to the flag bit. A capture that lands in the same cycle as that write wins, and the flag stays set.

Top module: `cap_timer`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 1) read 0x00 and `irq` is low.
- R2: Control bits [2:0] select the counter rate. Values 0 to 6 advance the counter once every 2^value bus clocks. The count reads at address 4 (high byte) and address 5 (low byte).
- R3: Control value 7 advances the counter once for each rising edge of `ext_clk`. That pin is synchronized with two flops, so the counter does not move while the pin is idle.
- R4: Status bits [5:4] select the capture edge: 01 rising only, 10 falling only, 11 both. A pin change applied before clock edge k1 is captured at edge k3, which is two edges later. The capture register receives the count held just before k3, and the flag (status bit 7) reads 1 only from k3 onward.
- R5: Edge select 00 disables capture. Edges of either direction leave the flag clear.
- R6: The capture value reads at address 2 (high byte) and address 3 (low byte). After a high-byte read, pin edges neither capture nor set the flag until the low byte is read. The low byte then returns the value paired with the high byte already read.
- R7: The flag clears only through a write of 0 to status bit 7 that follows a read of the status register made while the flag was set. Any status write ends that arming. A write of 0 without the arming read leaves the flag set.
- R8: If a capture and a flag-clearing write land on the same clock edge, the flag stays set and the capture register takes the new value.
- R9: `irq` is high exactly when the flag and the interrupt enable (status bit 6) are both 1.
- R10: Status bits 2, 1 and 0 are plain storage bits that read back as written. Status bit 3 and control bits [7:3] read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_clk | input | 1 | External counting clock, asynchronous |
| cap_in | input | 1 | Capture pin, asynchronous |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, acts at the next rising clock edge |
| rd_en | input | 1 | Read strobe; read side effects act at the next rising clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` while `rd_en` is high, else 0 |
| irq | output | 1 | Interrupt request |

## Verification
Register effects and read side effects act at the rising edge that ends the strobe cycle. The bench therefore drives strobes and pins at falling edges and samples `rdata` just before the next rising edge. A capture pin change lands three rising edges after it is driven. The bench reads the status once before that edge, expecting the flag still clear, and once after it, expecting the flag set. The expected capture value comes from a bench cycle counter, offset by one calibration read of the counter. Rate checks span 128 bus clocks, a multiple of every divisor, so each rate gives an exact count difference whatever phase the prescaler is in.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  localparam int unsigned CNT_W     = 16;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned PS_W      = 3;
  localparam int unsigned NUM_DIV   = 7;
  localparam int unsigned SYNC_DEPTH = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAPH = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAPL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNTH = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNTL = 3'd5;

  localparam int unsigned B_FLAG = 7;
  localparam int unsigned B_IE   = 6;
  localparam int unsigned B_ESEL = 4;
  localparam int unsigned B_MODE = 2;
  localparam int unsigned B_TOV  = 1;
  localparam int unsigned B_MAXD = 0;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

endpackage

// File: rtl/cap_timer_prescale.sv
module cap_timer_prescale
  import cap_timer_pkg::*;
#(
  parameter int unsigned SEL_W   = PS_W,
  parameter int unsigned DIV_N   = NUM_DIV,
  parameter int unsigned SYNC_N  = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic [SEL_W-1:0] ps,
  output logic             tick
);

  localparam int unsigned PRE_W  = DIV_N - 1;
  localparam int unsigned SEL_N  = 2 ** SEL_W;

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [SYNC_N:0]   ext_q, ext_d;
  logic              ext_rise;
  logic [SEL_N-1:0]  rate_vec;

  always_comb begin
    pre_d = pre_q + 1'b1;
    ext_d = {ext_q[SYNC_N-1:0], ext_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ext_q <= '0;
    end else begin
      pre_q <= pre_d;
      ext_q <= ext_d;
    end
  end

  assign ext_rise = ext_q[SYNC_N-1] & ~ext_q[SYNC_N];

  for (genvar k = 0; k < SEL_N; k++) begin : g_rate
    if (k == 0) begin : g_full
      assign rate_vec[k] = 1'b1;
    end else if (k < DIV_N) begin : g_div
      assign rate_vec[k] = &pre_q[k-1:0];
    end else begin : g_ext
      assign rate_vec[k] = ext_rise;
    end
  end

  assign tick = rate_vec[ps];

endmodule

// File: rtl/cap_timer_counter.sv
module cap_timer_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/cap_timer_capture.sv
module cap_timer_capture
  import cap_timer_pkg::*;
#(
  parameter int unsigned W      = CNT_W,
  parameter int unsigned SYNC_N = SYNC_DEPTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_in,
  input  edge_sel_e    esel,
  input  logic [W-1:0] cnt,
  input  logic         hold_set,
  input  logic         hold_clr,
  output logic [W-1:0] cap_q,
  output logic         cap_take,
  output logic         hold
);

  logic [SYNC_N:0] pin_q, pin_d;
  logic            pin_rise, pin_fall, pin_hit;
  logic            hold_q, hold_d;

  always_comb begin
    pin_d    = {pin_q[SYNC_N-1:0], cap_in};
    pin_rise = pin_q[SYNC_N-1] & ~pin_q[SYNC_N];
    pin_fall = ~pin_q[SYNC_N-1] & pin_q[SYNC_N];
    pin_hit  = (esel[0] & pin_rise) | (esel[1] & pin_fall);
    cap_take = pin_hit & ~hold_q & ~hold_set;
    hold_d   = hold_q;
    if (hold_clr)      hold_d = 1'b0;
    else if (hold_set) hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      pin_q  <= pin_d;
      hold_q <= hold_d;
    end
  end

  // capture data carries no reset; it is undefined until the first event
  always_ff @(posedge clk) begin
    if (cap_take) cap_q <= cnt;
  end

  assign hold = hold_q;

endmodule

// File: rtl/cap_timer_regs.sv
module cap_timer_regs
  import cap_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cap_q,
  input  logic              cap_take,
  output logic [PS_W-1:0]   ps,
  output edge_sel_e         esel,
  output logic              hold_set,
  output logic              hold_clr,
  output logic              flag,
  output logic              ie,
  output logic              irq
);

  logic            wr_ctrl, wr_stat, rd_stat;
  logic [PS_W-1:0] ps_q, ps_d;
  edge_sel_e       esel_q, esel_d;
  logic            flag_q, flag_d;
  logic            arm_q, arm_d;
  logic            ie_q, ie_d;
  logic [2:0]      misc_q, misc_d;
  logic [BYTE_W-1:0] stat_rd;
  logic            unused_wbits;

  assign unused_wbits = &{1'b0, wdata[BYTE_W-1:PS_W], wdata[3]};

  always_comb begin
    wr_ctrl  = wr_en && (addr == A_CTRL);
    wr_stat  = wr_en && (addr == A_STAT);
    rd_stat  = rd_en && (addr == A_STAT);
    hold_set = rd_en && (addr == A_CAPH);
    hold_clr = rd_en && (addr == A_CAPL);

    ps_d   = wr_ctrl ? wdata[PS_W-1:0] : ps_q;
    esel_d = wr_stat ? edge_sel_e'(wdata[B_ESEL+1:B_ESEL]) : esel_q;
    ie_d   = wr_stat ? wdata[B_IE] : ie_q;
    misc_d = wr_stat ? {wdata[B_MODE], wdata[B_TOV], wdata[B_MAXD]} : misc_q;

    arm_d = arm_q;
    if (wr_stat)               arm_d = 1'b0;
    else if (rd_stat && flag_q) arm_d = 1'b1;

    flag_d = flag_q;
    if (cap_take)                             flag_d = 1'b1;
    else if (wr_stat && arm_q && !wdata[B_FLAG]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= '0;
      esel_q <= EDGE_OFF;
      ie_q   <= 1'b0;
      misc_q <= '0;
      arm_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      ps_q   <= ps_d;
      esel_q <= esel_d;
      ie_q   <= ie_d;
      misc_q <= misc_d;
      arm_q  <= arm_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    stat_rd          = '0;
    stat_rd[B_FLAG]  = flag_q;
    stat_rd[B_IE]    = ie_q;
    stat_rd[B_ESEL+1:B_ESEL] = esel_q;
    stat_rd[B_MODE]  = misc_q[2];
    stat_rd[B_TOV]   = misc_q[1];
    stat_rd[B_MAXD]  = misc_q[0];

    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        A_CTRL:  rdata = {{(BYTE_W-PS_W){1'b0}}, ps_q};
        A_STAT:  rdata = stat_rd;
        A_CAPH:  rdata = cap_q[CNT_W-1:BYTE_W];
        A_CAPL:  rdata = cap_q[BYTE_W-1:0];
        A_CNTH:  rdata = cnt[CNT_W-1:BYTE_W];
        A_CNTL:  rdata = cnt[BYTE_W-1:0];
        default: rdata = '0;
      endcase
    end
  end

  assign ps   = ps_q;
  assign esel = esel_q;
  assign flag = flag_q;
  assign ie   = ie_q;
  assign irq  = flag_q & ie_q;

endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              cap_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq
);

  logic [1:0]       rst_sh;
  logic             rst_ni;
  logic             tick;
  logic [PS_W-1:0]  ps;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cap_q;
  logic             cap_take, hold, hold_set, hold_clr;
  logic             flag, ie;
  edge_sel_e        esel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_ni = rst_sh[1];

  cap_timer_prescale #(.SEL_W(PS_W), .DIV_N(NUM_DIV), .SYNC_N(SYNC_DEPTH)) u_pre (
    .clk(clk), .rst_n(rst_ni), .ext_clk(ext_clk), .ps(ps), .tick(tick)
  );

  cap_timer_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .cnt(cnt)
  );

  cap_timer_capture #(.W(CNT_W), .SYNC_N(SYNC_DEPTH)) u_cap (
    .clk(clk), .rst_n(rst_ni), .cap_in(cap_in), .esel(esel), .cnt(cnt),
    .hold_set(hold_set), .hold_clr(hold_clr),
    .cap_q(cap_q), .cap_take(cap_take), .hold(hold)
  );

  cap_timer_regs u_regs (
    .clk(clk), .rst_n(rst_ni), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cnt(cnt), .cap_q(cap_q),
    .cap_take(cap_take), .ps(ps), .esel(esel), .hold_set(hold_set),
    .hold_clr(hold_clr), .flag(flag), .ie(ie), .irq(irq)
  );

endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk
  import cap_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [PS_W-1:0]   ps,
  input logic [CNT_W-1:0]  cnt,
  input logic              cap_take,
  input logic              hold,
  input logic [CNT_W-1:0]  cap_q,
  input logic              flag,
  input logic              ie,
  input logic              irq,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wflag
);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + 1'b1)); // R2

  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)); // R2

  AST_EXT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ps == '1) |=> (ps != '1 || !tick)); // R3

  AST_TAKE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_take |=> flag); // R4

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(cap_q)); // R6

  AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr_en && addr == A_STAT && !wflag)); // R7

  AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ie)); // R9

endmodule

bind cap_timer cap_timer_chk u_chk (
  .clk(clk), .rst_n(rst_ni), .tick(tick), .ps(ps), .cnt(cnt),
  .cap_take(cap_take), .hold(hold), .cap_q(cap_q), .flag(flag), .ie(ie),
  .irq(irq), .wr_en(wr_en), .addr(addr), .wflag(wdata[7])
);

// File: tb/cap_timer_bench.sv
`timescale 1ns/1ps
module cap_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       cap_in = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int         n_chk = 0;
  int         n_bad = 0;
  int         cyc = 0;
  bit         done = 1'b0;
  logic [15:0] off;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cap_timer u_cap_timer (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .cap_in(cap_in),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_cap(output logic [15:0] v);
    logic [7:0] h, l;
    bus_read(3'd2, h);
    bus_read(3'd3, l);
    v = {h, l};
  endtask

  // drive the pin, return the expected captured count (valid while rate = 1)
  task automatic pin_edge(input logic v, output logic [15:0] exp);
    cap_in = v;
    exp = 16'(cyc) + off + 16'd2;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_flag(input logic [7:0] keep);
    logic [7:0] s;
    bus_read(3'd1, s);
    bus_write(3'd1, keep & 8'h7F);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_read(3'd0, d);
    check(d == 8'h00, "R1 control after reset", d, 0);
    bus_read(3'd1, d);
    check(d == 8'h00, "R1 status after reset", d, 0);
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
  endtask

  task automatic t_calibrate();
    logic [7:0] l, h;
    int c;
    bus_read(3'd5, l);
    c = cyc;
    bus_read(3'd4, h);
    off = {h, 8'(l + 8'd1)} - 16'(c);
  endtask

  task automatic t_rise_mode();
    logic [15:0] exp, got;
    logic [7:0] s;
    bus_write(3'd1, 8'h10);
    cap_in = 1'b1;
    exp = 16'(cyc) + off + 16'd2;
    repeat (2) @(negedge clk);
    bus_read(3'd1, s);
    check(s[7] == 1'b0, "R4 flag not yet set before third edge", s[7], 0);
    bus_read(3'd1, s);
    check(s[7] == 1'b1, "R4 flag set after rising edge", s[7], 1);
    read_cap(got);
    check(got == exp, "R4 rising edge capture value", got, exp);
    clear_flag(8'h10);
    bus_read(3'd1, s);
    check(s[7] == 1'b0, "R7 flag cleared by read then write 0", s[7], 0);
    pin_edge(1'b0, exp);
    bus_read(3'd1, s);
    check(s[7] == 1'b0, "R4 falling edge ignored in rise mode", s[7], 0);
    read_cap(exp);
    check(exp == got, "R4 capture unchanged in rise mode on fall", exp, got);
  endtask

  task automatic t_fall_mode();
    logic [15:0] exp, got;
    logic [7:0] s;
    bus_write(3'd1, 8'h20);
    pin_edge(1'b1, exp);
    bus_read(3'd1, s);
    check(s[7] == 1'b0, "R4 rising edge ignored in fall mode", s[7], 0);
    pin_edge(1'b0, exp);
    bus_read(3'd1, s);
    check(s[7] == 1'b1, "R4 flag set on falling edge", s[7], 1);
    read_cap(got);
    check(got == exp, "R4 falling edge capture value", got, exp);
    clear_flag(8'h20);
  endtask

  task automatic t_both_mode();
    logic [15:0] exp, got;
    logic [7:0] s;
    bus_write(3'd1, 8'h30);
    pin_edge(1'b1, exp);
    read_cap(got);
    check(got == exp, "R4 both mode rising capture", got, exp);
    clear_flag(8'h30);
    pin_edge(1'b0, exp);
    read_cap(got);
    check(got == exp, "R4 both mode falling capture", got, exp);
    bus_read(3'd1, s);
    bus_write(3'd1, 8'hB0);
    bus_write(3'd1, 8'h30);
    bus_read(3'd1, s);
    check(s[7] == 1'b1, "R7 write 0 without arming read keeps flag", s[7], 1);
    clear_flag(8'h30);
  endtask

  task automatic t_off_mode();
    logic [15:0] exp;
    logic [7:0] s;
    bus_write(3'd1, 8'h00);
    pin_edge(1'b1, exp);
    pin_edge(1'b0, exp);
    bus_read(3'd1, s);
    check(s[7] == 1'b0, "R5 edge select 00 never sets flag", s[7], 0);
  endtask

  task automatic t_hold();
    logic [15:0] expa, expb, got;
    logic [7:0] h, l, s;
    bus_write(3'd1, 8'h30);
    pin_edge(1'b1, expa);
    clear_flag(8'h30);
    bus_read(3'd2, h);
    check(h == expa[15:8], "R6 high byte value", h, expa[15:8]);
    pin_edge(1'b0, expb);
    bus_read(3'd1, s);
    check(s[7] == 1'b0, "R6 edge during hold sets no flag", s[7], 0);
    bus_read(3'd3, l);
    check(l == expa[7:0], "R6 low byte paired with high byte", l, expa[7:0]);
    pin_edge(1'b1, expb);
    read_cap(got);
    check(got == expb, "R6 capture resumes after low byte read", got, expb);
    clear_flag(8'h30);
  endtask

  task automatic t_race();
    logic [15:0] exp, got;
    logic [7:0] s;
    pin_edge(1'b0, exp);
    bus_read(3'd1, s);
    cap_in = 1'b1;
    exp = 16'(cyc) + off + 16'd2;
    repeat (2) @(negedge clk);
    bus_write(3'd1, 8'h30);
    bus_read(3'd1, s);
    check(s[7] == 1'b1, "R8 capture beats same-edge clear", s[7], 1);
    read_cap(got);
    check(got == exp, "R8 capture value on race edge", got, exp);
  endtask

  task automatic t_irq();
    logic [7:0] s;
    #1 check(irq == 1'b0, "R9 irq low with flag set and ie 0", irq, 0);
    bus_write(3'd1, 8'hF0);
    #1 check(irq == 1'b1, "R9 irq high with flag and ie", irq, 1);
    clear_flag(8'h70);
    #1 check(irq == 1'b0, "R9 irq low after flag clear", irq, 0);
    bus_read(3'd1, s);
    check(s == 8'h70, "R9 status after clear with ie", s, 8'h70);
  endtask

  task automatic t_misc();
    logic [7:0] s;
    bus_write(3'd1, 8'h8F);
    bus_read(3'd1, s);
    check(s == 8'h07, "R10 storage bits read back, bit3 zero", s, 8'h07);
    bus_write(3'd1, 8'h02);
    bus_read(3'd1, s);
    check(s == 8'h02, "R10 storage bits rewrite", s, 8'h02);
    bus_write(3'd0, 8'hF8);
    bus_read(3'd0, s);
    check(s == 8'h00, "R10 control upper bits read 0", s, 0);
  endtask

  task automatic t_prescale();
    logic [7:0] a, b, d;
    for (int p = 0; p < 7; p++) begin
      bus_write(3'd0, 8'(p));
      bus_read(3'd0, d);
      check(d == 8'(p), "R2 rate select readback", d, p);
      bus_read(3'd5, a);
      repeat (127) @(negedge clk);
      bus_read(3'd5, b);
      check(8'(b - a) == 8'(128 >> p), "R2 count advance over 128 clocks", 8'(b - a), 128 >> p);
    end
  endtask

  task automatic t_ext();
    logic [7:0] a, b;
    bus_write(3'd0, 8'h07);
    repeat (4) @(negedge clk);
    bus_read(3'd5, a);
    repeat (20) @(negedge clk);
    bus_read(3'd5, b);
    check(b == a, "R3 counter idle without ext pulses", b, a);
    for (int i = 0; i < 10; i++) begin
      ext_clk = 1'b1;
      repeat (3) @(negedge clk);
      ext_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    bus_read(3'd5, a);
    check(8'(a - b) == 8'd10, "R3 one count per ext rising edge", 8'(a - b), 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_calibrate();
    t_rise_mode();
    t_fall_mode();
    t_both_mode();
    t_off_mode();
    t_hold();
    t_race();
    t_irq();
    t_misc();
    t_prescale();
    t_ext();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule